// File: doc/BRIEF.md
# Integer Micro-op Port Steering with Asymmetric Capabilities

This block sits between decode and the integer schedulers. Each cycle it is offered a group of up to six decoded micro-ops, each marked with an operation class, and it places each accepted micro-op into one of six per-port scheduling queues. The six ports are four ALU ports and two address-generation ports. The ALU ports differ in what they can take:

- Branches are restricted to two of them.
- Signed multiply goes to a single port.
- CRC goes to a different single port.

Placement is made in program order. Each micro-op goes to the least-occupied legal port that still has space. When one micro-op cannot be placed, it and all younger micro-ops in the group are refused, and upstream re-presents them later. Each queue exposes its head entry, a valid flag and an occupancy count, and it is drained through a simple per-port pop.

Top module: `port_steer`

## Requirements
- R1: After synchronous reset every queue reports occupancy 0 and its head valid flag is low.
- R2: Every accepted micro-op enters its chosen queue; entries leave a queue in the order they entered, younger group slots behind older ones.
- R3: A branch (class code 1) may be placed only on port 0 or port 1, and at most two branches are accepted per cycle; a third branch is refused.
- R4: A signed multiply (class code 2) may be placed only on port 1.
- R5: A CRC operation (class code 3) may be placed only on port 2.
- R6: A simple ALU operation (class code 0, and the unused codes 5 to 7) may go to any of ports 0 to 3. The chosen port is the legal port with the fewest entries, and ties go to the lowest index.
- R7: A load or store address operation (class code 4) goes only to port 4 or 5, under the same fewest-entries, lowest-index rule.
- R8: Slots are steered strictly in order. Once a valid slot is refused, no younger slot in that group is accepted. Invalid slots neither block nor are accepted.
- R9: A queue holds at most 14 entries. A full queue accepts nothing. A queue that becomes full part-way through a group is unavailable to the later slots of that group.
- R10: A pop removes the head entry of a non-empty queue. A pop on an empty queue has no effect. A slot freed by a pop becomes usable for pushes only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | GROUP | Valid flag per group slot, slot 0 oldest |
| in_class | input | 3*GROUP | Operation class per slot, slot s at bits [3s+2:3s] |
| in_tag | input | TAG_W*GROUP | Payload per slot, slot s at bits [TAG_W*s +: TAG_W] |
| accept | output | GROUP | Slot placed into a queue this cycle |
| pop | input | 6 | Per-port request to remove the queue head |
| out_valid | output | 6 | Per-port queue non-empty |
| out_tag | output | TAG_W*6 | Per-port head payload |
| occupancy | output | 4*6 | Per-port entry count, port p at bits [4p+3:4p] |

## Verification
Uniform ALU groups show whether least-occupied selection with low-index tie-breaking spreads work across ports. Mixed groups of multiply, CRC, branch and memory classes show whether capability masks and branch capping are applied in the right slot. Sparse valid patterns separate invalid slots from refused ones. Repeated groups of a single class fill one queue, which shows the in-group full condition, the blocking of younger slots, and the fact that a same-cycle pop does not free a slot.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int NUM_PORTS = 6;
    localparam int PORT_W    = 3;
    localparam int CLASS_W   = 3;
    localparam int MAX_BR    = 2;

    typedef enum logic [CLASS_W-1:0] {
        OP_ALU    = 3'd0,
        OP_BRANCH = 3'd1,
        OP_MUL    = 3'd2,
        OP_CRC    = 3'd3,
        OP_MEM    = 3'd4
    } op_class_t;

    // Ports allowed for each class; bit p set means port p may take it.
    function automatic logic [NUM_PORTS-1:0] legal_ports(logic [CLASS_W-1:0] code);
        case (code)
            OP_BRANCH: legal_ports = 6'b000011;
            OP_MUL:    legal_ports = 6'b000010;
            OP_CRC:    legal_ports = 6'b000100;
            OP_MEM:    legal_ports = 6'b110000;
            default:   legal_ports = 6'b001111;
        endcase
    endfunction

endpackage

// File: rtl/steer_pick.sv
module steer_pick
    import steer_pkg::*;
#(
    parameter int GROUP = 6,
    parameter int DEPTH = 14,
    parameter int CW    = 4
) (
    input  logic [GROUP-1:0]                    slot_valid,
    input  logic [GROUP-1:0][CLASS_W-1:0]       slot_class,
    input  logic [NUM_PORTS-1:0][CW-1:0]        port_fill,
    output logic [GROUP-1:0]                    slot_take,
    output logic [GROUP-1:0][PORT_W-1:0]        slot_port
);

    logic [NUM_PORTS-1:0][CW-1:0] trial;
    logic [NUM_PORTS-1:0]         allow;
    logic [1:0]                   br_used;
    logic                         halted;
    logic                         found;
    logic [PORT_W-1:0]            best;

    always_comb begin
        trial     = port_fill;
        br_used   = '0;
        halted    = 1'b0;
        slot_take = '0;
        slot_port = '0;
        for (int s = 0; s < GROUP; s++) begin
            allow = legal_ports(slot_class[s]);
            if (slot_class[s] == OP_BRANCH && br_used >= 2'(MAX_BR))
                allow = '0;
            found = 1'b0;
            best  = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (allow[p] && trial[p] < CW'(DEPTH) &&
                    (!found || trial[p] < trial[best])) begin
                    found = 1'b1;
                    best  = PORT_W'(p);
                end
            end
            if (slot_valid[s] && !halted) begin
                if (found) begin
                    slot_take[s] = 1'b1;
                    slot_port[s] = best;
                    trial[best]  = trial[best] + CW'(1);
                    if (slot_class[s] == OP_BRANCH)
                        br_used = br_used + 2'd1;
                end else begin
                    halted = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/steer_queue.sv
module steer_queue #(
    parameter int GROUP = 6,
    parameter int DEPTH = 14,
    parameter int TAG_W = 8,
    parameter int CW    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [GROUP-1:0]            push,
    input  logic [GROUP-1:0][TAG_W-1:0] push_tag,
    input  logic                        pop,
    output logic [CW-1:0]               fill,
    output logic                        nonempty,
    output logic [TAG_W-1:0]            head
);

    localparam int PW = $clog2(DEPTH);

    logic [TAG_W-1:0]          store [DEPTH];
    logic [PW-1:0]             rd_ptr;
    logic [CW-1:0]             count;
    logic [GROUP-1:0][PW-1:0]  wr_idx;
    logic [CW-1:0]             n_push;
    logic                      do_pop;
    int                        offset;

    always_comb begin
        offset = 0;
        n_push = '0;
        for (int s = 0; s < GROUP; s++) begin
            wr_idx[s] = PW'((int'(rd_ptr) + int'(count) + offset) % DEPTH);
            if (push[s]) begin
                offset = offset + 1;
                n_push = n_push + CW'(1);
            end
        end
    end

    assign do_pop = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count + n_push - CW'(do_pop);
            if (do_pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < GROUP; s++) begin
            if (push[s])
                store[wr_idx[s]] <= push_tag[s];
        end
    end

    assign fill     = count;
    assign nonempty = (count != '0);
    assign head     = store[rd_ptr];

endmodule

// File: rtl/port_steer.sv
module port_steer
    import steer_pkg::*;
#(
    parameter int GROUP  = 6,
    parameter int QDEPTH = 14,
    parameter int TAG_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [GROUP-1:0]              in_valid,
    input  logic [GROUP*CLASS_W-1:0]      in_class,
    input  logic [GROUP*TAG_W-1:0]        in_tag,
    output logic [GROUP-1:0]              accept,
    input  logic [NUM_PORTS-1:0]          pop,
    output logic [NUM_PORTS-1:0]          out_valid,
    output logic [NUM_PORTS*TAG_W-1:0]    out_tag,
    output logic [NUM_PORTS*4-1:0]        occupancy
);

    localparam int CW = $clog2(QDEPTH + 1);

    logic [GROUP-1:0][CLASS_W-1:0]    cls_a;
    logic [GROUP-1:0][TAG_W-1:0]      tag_a;
    logic [GROUP-1:0][PORT_W-1:0]     sel;
    logic [NUM_PORTS-1:0][CW-1:0]     fill_a;
    logic [NUM_PORTS-1:0][TAG_W-1:0]  head_a;

    assign cls_a = in_class;
    assign tag_a = in_tag;

    steer_pick #(.GROUP(GROUP), .DEPTH(QDEPTH), .CW(CW)) u_pick (
        .slot_valid (in_valid),
        .slot_class (cls_a),
        .port_fill  (fill_a),
        .slot_take  (accept),
        .slot_port  (sel)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [GROUP-1:0] push_mask;
        for (genvar s = 0; s < GROUP; s++) begin : g_slot
            assign push_mask[s] = accept[s] && (sel[s] == PORT_W'(p));
        end

        steer_queue #(.GROUP(GROUP), .DEPTH(QDEPTH), .TAG_W(TAG_W), .CW(CW)) u_q (
            .clk      (clk),
            .rst      (rst),
            .push     (push_mask),
            .push_tag (tag_a),
            .pop      (pop[p]),
            .fill     (fill_a[p]),
            .nonempty (out_valid[p]),
            .head     (head_a[p])
        );

        assign occupancy[p*4 +: 4] = 4'(fill_a[p]);
    end

    assign out_tag = head_a;

endmodule

// File: rtl/steer_checker.sv
module steer_checker
    import steer_pkg::*;
#(
    parameter int GROUP  = 6,
    parameter int QDEPTH = 14
) (
    input logic                       clk,
    input logic                       rst,
    input logic [GROUP-1:0]           in_valid,
    input logic [GROUP*CLASS_W-1:0]   in_class,
    input logic [GROUP-1:0]           accept,
    input logic [NUM_PORTS-1:0]       pop,
    input logic [NUM_PORTS-1:0]       out_valid,
    input logic [NUM_PORTS*4-1:0]     occupancy
);

    logic [GROUP-1:0] is_br;
    always_comb begin
        for (int s = 0; s < GROUP; s++)
            is_br[s] = (in_class[s*CLASS_W +: CLASS_W] == OP_BRANCH);
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (occupancy == '0 && out_valid == '0));

    assert_branch_cap_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(accept & is_br) <= MAX_BR);

    for (genvar s = 1; s < GROUP; s++) begin : g_order
        assert_in_order_R8: assert property (@(posedge clk) disable iff (rst)
            accept[s] |-> (accept[s-1] || !in_valid[s-1]));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_q
        assert_occ_limit_R9: assert property (@(posedge clk) disable iff (rst)
            occupancy[p*4 +: 4] <= 4'(QDEPTH));

        assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (occupancy[p*4 +: 4] == 4'(QDEPTH) && !pop[p]) |=>
            occupancy[p*4 +: 4] == 4'(QDEPTH));

        assert_pop_drain_R10: assert property (@(posedge clk) disable iff (rst)
            (accept == '0 && pop[p] && occupancy[p*4 +: 4] != 4'd0) |=>
            occupancy[p*4 +: 4] == $past(occupancy[p*4 +: 4]) - 4'd1);
    end

endmodule

bind port_steer steer_checker #(.GROUP(GROUP), .QDEPTH(QDEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .accept    (accept),
    .pop       (pop),
    .out_valid (out_valid),
    .occupancy (occupancy)
);

// File: tb/test_port_steer.sv
`timescale 1ns/1ps
module test_port_steer;

    localparam int GROUP = 6;
    localparam int TAG_W = 8;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [GROUP-1:0]       in_valid = '0;
    logic [GROUP*3-1:0]     in_class = '0;
    logic [GROUP*TAG_W-1:0] in_tag = '0;
    logic [GROUP-1:0]       accept;
    logic [5:0]             pop = '0;
    logic [5:0]             out_valid;
    logic [6*TAG_W-1:0]     out_tag;
    logic [23:0]            occupancy;

    int n_checks = 0;
    int n_fails  = 0;
    logic [5:0] acc;

    port_steer #(.GROUP(GROUP), .QDEPTH(14), .TAG_W(TAG_W)) i_port_steer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_tag(in_tag), .accept(accept), .pop(pop), .out_valid(out_valid),
        .out_tag(out_tag), .occupancy(occupancy)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [5:0]  v;
        logic [17:0] c;
        logic [5:0]  a;
        logic [23:0] o;
        logic [3:0]  req;
    } vec_t;

    // Class per slot {s5..s0}: 0 ALU, 1 branch, 2 multiply, 3 CRC, 4 memory.
    // Occupancy {p5..p0}, one hex digit per port, starting from empty queues.
    localparam vec_t VECS [6] = '{
        // R6: six ALU ops spread by fewest entries, low index on ties
        '{v:6'h3F, c:18'h0, a:6'h3F, o:24'h001122, req:4'd6},
        // R3: third branch refused and younger slots held
        '{v:6'h3F, c:{3'd0,3'd0,3'd0,3'd1,3'd1,3'd1}, a:6'h03, o:24'h000011, req:4'd3},
        // R4 and R7: multiplies to port 1, memory ops to ports 4 and 5
        '{v:6'h3F, c:{3'd4,3'd4,3'd4,3'd3,3'd2,3'd2}, a:6'h3F, o:24'h120120, req:4'd4},
        // R5: mixed group, CRC lands on port 2
        '{v:6'h3F, c:{3'd0,3'd2,3'd3,3'd1,3'd0,3'd4}, a:6'h3F, o:24'h011121, req:4'd5},
        // R8: invalid slots are skipped, not blocking
        '{v:6'h15, c:18'h0, a:6'h15, o:24'h000111, req:4'd8},
        // R3: two branches interleaved with ALU ops
        '{v:6'h3F, c:{3'd0,3'd0,3'd0,3'd1,3'd0,3'd1}, a:6'h3F, o:24'h001122, req:4'd3}
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = '0; pop = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic [5:0] v, input logic [17:0] c,
                        input logic [5:0] p, output logic [5:0] a);
        @(negedge clk);
        in_valid = v; in_class = c; pop = p;
        #1 a = accept;
        @(posedge clk);
        #1 in_valid = '0; pop = '0;
    endtask

    function automatic logic [3:0] occ(input int p);
        return occupancy[p*4 +: 4];
    endfunction

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < GROUP; s++) in_tag[s*TAG_W +: TAG_W] = 8'(8'h10 + s);

        // R1: reset state
        do_reset();
        check(1, 32'(occupancy), 32'h0);
        check(1, 32'(out_valid), 32'h0);

        // Table walk, each from empty queues
        for (int i = 0; i < 6; i++) begin
            do_reset();
            step(VECS[i].v, VECS[i].c, 6'h0, acc);
            check(int'(VECS[i].req), 32'(acc), 32'(VECS[i].a));
            check(int'(VECS[i].req), 32'(occupancy), 32'(VECS[i].o));
        end

        // R2: program order inside a queue
        do_reset();
        step(6'h3F, 18'h0, 6'h0, acc);
        check(2, 32'(out_tag[7:0]), 32'h10);
        step(6'h00, 18'h0, 6'b000001, acc);
        check(2, 32'(out_tag[7:0]), 32'h14);
        check(2, 32'(occ(0)), 32'd1);

        // R10: pop on an empty queue has no effect
        step(6'h00, 18'h0, 6'b100000, acc);
        check(10, 32'(occ(5)), 32'd0);
        check(10, 32'(out_valid[5]), 32'd0);

        // R9: fill port 1 with multiplies, queue fills inside a group
        do_reset();
        step(6'h3F, {6{3'd2}}, 6'h0, acc);
        step(6'h3F, {6{3'd2}}, 6'h0, acc);
        step(6'h01, {6{3'd2}}, 6'h0, acc);
        check(9, 32'(occ(1)), 32'd13);
        step(6'h03, {6{3'd2}}, 6'h0, acc);
        check(9, 32'(acc), 32'h01);
        check(9, 32'(occ(1)), 32'd14);
        // R10: same-cycle pop does not free a slot for a push
        step(6'h01, {6{3'd2}}, 6'b000010, acc);
        check(10, 32'(acc), 32'h00);
        check(10, 32'(occ(1)), 32'd13);
        step(6'h01, {6{3'd2}}, 6'h0, acc);
        check(10, 32'(acc), 32'h01);
        check(9, 32'(occ(1)), 32'd14);

        // R8: full CRC port blocks its slot and every younger one
        do_reset();
        step(6'h3F, {6{3'd3}}, 6'h0, acc);
        step(6'h3F, {6{3'd3}}, 6'h0, acc);
        step(6'h3F, {6{3'd3}}, 6'h0, acc);
        check(5, 32'(acc), 32'h03);
        check(5, 32'(occ(2)), 32'd14);
        step(6'h07, {3'd0,3'd0,3'd0,3'd0,3'd3,3'd0}, 6'h0, acc);
        check(8, 32'(acc), 32'h01);
        check(8, 32'(occ(0)), 32'd1);
        check(8, 32'(occ(1)) + 32'(occ(3)), 32'd0);

        $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
        $finish;
    end

endmodule